// File: doc/BRIEF.md
# Multi-Length Synchronous Serial Receiver

This block is the receive half of a clocked synchronous serial unit framed by an active-low select line. While select is asserted, it samples a serial data line on each rising edge of the serial clock. The clock idles low. It builds frames one, two or four bytes long. The serial clock, data and select inputs are first passed through a synchroniser into the system clock domain, and clock edges are detected there. The serial clock must therefore run well below the system clock.

When a whole frame has arrived, its bytes are copied into four byte-wide result registers, and a full flag is raised. The slot each byte lands in depends on the bit order. Software starts reception with a throwaway read of result register 0 after setting the enable. After each frame, it reads register 0 again to clear the flag and allow the next frame. If a frame finishes while the flag is still set, the frame is dropped and a sticky overrun bit is raised. The interrupt line is the full flag gated by an interrupt enable.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, full, overrun and irq are 0 and all four result registers read 0.
- R2: With rx_en high, frames are ignored until result register 0 has been read at least once since rx_en rose: full stays 0 and the registers keep their values.
- R3: In 8-bit mode (len_sel=00) with lsb_first=0, the first bit received becomes bit 7 of register 0.
- R4: In 8-bit mode with lsb_first=1, the first bit received becomes bit 0 of register 0.
- R5: In 16-bit mode (len_sel=01), when lsb_first=0 the first byte goes to register 0 and the second to register 1. When lsb_first=1 the first byte goes to register 1 and the second to register 0.
- R6: In 32-bit mode (len_sel=1x), when lsb_first=0 the bytes fill registers 0,1,2,3 in arrival order. When lsb_first=1 they fill registers 3,2,1,0.
- R7: full rises only after the last bit of a whole frame, never after an intermediate byte.
- R8: A read strobe (rd_en=1) at address 0 clears full; a read strobe at any other address leaves it set.
- R9: A frame that completes while full is 1 sets overrun and leaves full and all registers unchanged. overrun clears when rx_en is 0.
- R10: Raising cs_n in mid-frame discards the partial frame, and the next frame is assembled from its own bits only.
- R11: irq is 1 exactly when full is 1 and irq_en is 1.
- R12: Data is taken at the rising sclk edge; changes on sdin while sclk is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| lsb_first | input | 1 | 1: bit 0 of each byte first; 0: bit 7 first |
| len_sel | input | 2 | Frame length: 00 one byte, 01 two bytes, 1x four bytes |
| irq_en | input | 1 | Receive interrupt enable |
| sclk | input | 1 | Serial clock, idle low |
| sdin | input | 1 | Serial data input |
| cs_n | input | 1 | Active-low frame select |
| rd_en | input | 1 | Read strobe for the result registers |
| rd_addr | input | 2 | Result register index |
| rd_data | output | 8 | Contents of the addressed result register |
| full | output | 1 | Frame received, not yet read |
| overrun | output | 1 | A frame was lost while full was set |
| irq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, four result registers and a two-stage synchroniser. With these values all three frame lengths and both bit orders can be reached, as can the reversal of the register mapping at 16 and 32 bits. Each serial bit spans eight system clocks, and the data line is deliberately corrupted while sclk is high. This exposes any sampling on the wrong edge or any slip in the synchroniser alignment.

// File: rtl/sync_serial_rx.sv
module sync_serial_rx #(
  parameter int BYTE_W      = 8,
  parameter int NREG        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_en,
  input  logic                     lsb_first,
  input  logic [1:0]               len_sel,
  input  logic                     irq_en,
  input  logic                     sclk,
  input  logic                     sdin,
  input  logic                     cs_n,
  input  logic                     rd_en,
  input  logic [$clog2(NREG)-1:0]  rd_addr,
  output logic [BYTE_W-1:0]        rd_data,
  output logic                     full,
  output logic                     overrun,
  output logic                     irq
);
  localparam int BW = $clog2(BYTE_W);
  localparam int RW = $clog2(NREG);

  logic [SYNC_STAGES-1:0] sck_q, sdi_q, csn_q;
  logic                   sck_d;
  logic [BW-1:0]          bit_cnt;
  logic [RW-1:0]          byte_cnt;
  logic [BYTE_W-1:0]      shreg;
  logic [NREG-1:0][BYTE_W-1:0] stg, rdr;
  logic                   armed;
  logic [RW:0]            nb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      sdi_q <= '0;
      csn_q <= '1;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-2:0], sclk};
      sdi_q <= {sdi_q[SYNC_STAGES-2:0], sdin};
      csn_q <= {csn_q[SYNC_STAGES-2:0], cs_n};
      sck_d <= sck_q[SYNC_STAGES-1];
    end

  wire rise   = sck_q[SYNC_STAGES-1] & ~sck_d;
  wire sel    = ~csn_q[SYNC_STAGES-1];
  wire bit_in = sdi_q[SYNC_STAGES-1];

  always_comb
    case (len_sel)
      2'b00:   nb = (RW+1)'(1);
      2'b01:   nb = (RW+1)'(2);
      default: nb = (RW+1)'(NREG);
    endcase

  wire [RW:0] nb_m1     = nb - 1'b1;
  wire        last_byte = ({1'b0, byte_cnt} == nb_m1);
  wire [RW:0] rev_slot  = nb_m1 - {1'b0, byte_cnt};
  wire [RW-1:0] slot    = lsb_first ? rev_slot[RW-1:0] : byte_cnt;

  wire [BYTE_W-1:0] shift_nxt = lsb_first ? {bit_in, shreg[BYTE_W-1:1]}
                                          : {shreg[BYTE_W-2:0], bit_in};
  wire take     = rx_en & armed & sel & rise;
  wire byte_end = take & (bit_cnt == BW'(BYTE_W-1));
  wire done     = byte_end & last_byte;
  wire rd_clear = rd_en & (rd_addr == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
    end else if (!rx_en || !sel) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else if (take) begin
      shreg   <= shift_nxt;
      bit_cnt <= bit_cnt + 1'b1;
      if (byte_end) byte_cnt <= last_byte ? '0 : byte_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stg <= '0;
    else if (byte_end) stg[slot] <= shift_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdr <= '0;
    else if (done && !full)
      for (int k = 0; k < NREG; k++)
        if (k < int'(nb)) rdr[k] <= (RW'(k) == slot) ? shift_nxt : stg[k];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full    <= 1'b0;
      overrun <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (done && !full) full <= 1'b1;
      else if (rd_clear) full <= 1'b0;
      if (!rx_en) overrun <= 1'b0;
      else if (done && full) overrun <= 1'b1;
      if (!rx_en) armed <= 1'b0;
      else if (rd_clear) armed <= 1'b1;
    end

  assign rd_data = rdr[rd_addr];
  assign irq     = full & irq_en;
endmodule

module sync_serial_rx_chk #(
  parameter int BYTE_W = 8,
  parameter int NREG   = 4,
  parameter int BW     = 3,
  parameter int RW     = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rx_en,
  input logic                   rd_clear,
  input logic                   done,
  input logic                   armed,
  input logic                   sel,
  input logic [BW-1:0]          bit_cnt,
  input logic [RW-1:0]          byte_cnt,
  input logic [NREG*BYTE_W-1:0] regs,
  input logic                   full,
  input logic                   overrun,
  input logic                   irq,
  input logic                   irq_en
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (!full && !overrun && !irq));
  a_r2_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !full) |=> ($stable(regs) && !full));
  a_r7_full_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(done));
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !done) |=> !full);
  a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && rx_en) |=> (overrun && $stable(regs)));
  a_r10_abort_counters: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel) |=> (bit_cnt == '0 && byte_cnt == '0));
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (full && irq_en));
endmodule

bind sync_serial_rx sync_serial_rx_chk #(
  .BYTE_W(BYTE_W), .NREG(NREG), .BW(BW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_clear(rd_clear), .done(done),
  .armed(armed), .sel(sel), .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .regs(rdr),
  .full(full), .overrun(overrun), .irq(irq), .irq_en(irq_en)
);

// File: tb/test_sync_serial_rx.sv
module test_sync_serial_rx;
  logic clk = 0, rst_n = 0, rx_en = 0, lsb_first = 0, irq_en = 0;
  logic sclk = 0, sdin = 0, cs_n = 1, rd_en = 0;
  logic [1:0] len_sel = 0, rd_addr = 0;
  logic [7:0] rd_data;
  logic full, overrun, irq;
  int total = 0, bad = 0;
  logic [7:0] m [4];

  always #5 clk = ~clk;

  sync_serial_rx i_sync_serial_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .lsb_first(lsb_first), .len_sel(len_sel),
    .irq_en(irq_en), .sclk(sclk), .sdin(sdin), .cs_n(cs_n), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .full(full), .overrun(overrun), .irq(irq));

  // {len_sel, lsb_first, word}; byte k of word is sent k-th
  localparam logic [34:0] VEC [8] = '{
    {2'b00, 1'b0, 32'h0000_00A5}, {2'b00, 1'b1, 32'h0000_0031},
    {2'b01, 1'b0, 32'h0000_C3D2}, {2'b01, 1'b1, 32'h0000_1E87},
    {2'b10, 1'b0, 32'h1234_5678}, {2'b10, 1'b1, 32'h9ABC_DEF0},
    {2'b11, 1'b0, 32'h0F1E_2D3C}, {2'b11, 1'b1, 32'hE1D2_C3B4}};

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdin = b; wclk(4);
    sclk = 1; wclk(2);
    sdin = ~b; wclk(2);   // R12: garbage while high
    sclk = 0;
  endtask

  task automatic send_byte(logic [7:0] b, logic lsb);
    for (int i = 0; i < 8; i++) send_bit(lsb ? b[i] : b[7-i]);
  endtask

  task automatic send_frame(logic [1:0] len, logic lsb, logic [31:0] w);
    int nb = (len == 0) ? 1 : (len == 1) ? 2 : 4;
    len_sel = len; lsb_first = lsb;
    cs_n = 0; wclk(4);
    for (int k = 0; k < nb; k++) send_byte(w[8*k +: 8], lsb);
    wclk(4); cs_n = 1; wclk(8);
  endtask

  task automatic model(logic [1:0] len, logic lsb, logic [31:0] w);
    int nb = (len == 0) ? 1 : (len == 1) ? 2 : 4;
    for (int k = 0; k < nb; k++) m[lsb ? nb-1-k : k] = w[8*k +: 8];
  endtask

  task automatic read0();
    rd_addr = 0; rd_en = 1; wclk(1); rd_en = 0; wclk(1);
  endtask

  task automatic check_regs(string req);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); wclk(1);
      chk(req, {24'h0, rd_data}, {24'h0, m[a]});
    end
  endtask

  function automatic string reqname(logic [1:0] len, logic lsb);
    if (len == 0) return lsb ? "R4" : "R3";
    return (len == 1) ? "R5" : "R6";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4; a++) m[a] = 8'h00;
    wclk(3); rst_n = 1; wclk(2);
    chk("R1 full", {31'h0, full}, 0);
    chk("R1 overrun", {31'h0, overrun}, 0);
    chk("R1 irq", {31'h0, irq}, 0);
    check_regs("R1 regs");

    rx_en = 1; irq_en = 1; wclk(2);
    send_frame(2'b00, 1'b0, 32'h5A);
    chk("R2 full unarmed", {31'h0, full}, 0);
    check_regs("R2 regs unarmed");
    read0();

    for (int v = 0; v < 8; v++) begin
      send_frame(VEC[v][34:33], VEC[v][32], VEC[v][31:0]);
      model(VEC[v][34:33], VEC[v][32], VEC[v][31:0]);
      chk("R7 full after frame", {31'h0, full}, 1);
      chk("R11 irq with enable", {31'h0, irq}, 1);
      check_regs({reqname(VEC[v][34:33], VEC[v][32]), " R12 mapping"});
      read0();
      chk("R8 cleared by read0", {31'h0, full}, 0);
    end

    // R7: no flag after the first byte of a 16-bit frame
    len_sel = 2'b01; lsb_first = 0; cs_n = 0; wclk(4);
    send_byte(8'h66, 0); wclk(10);
    chk("R7 mid-frame", {31'h0, full}, 0);
    send_byte(8'h99, 0); wclk(4); cs_n = 1; wclk(8);
    model(2'b01, 0, 32'h9966);
    chk("R7 end of frame", {31'h0, full}, 1);

    // R8: other address does not clear
    rd_addr = 2'd1; rd_en = 1; wclk(1); rd_en = 0; wclk(1);
    chk("R8 addr1 keeps full", {31'h0, full}, 1);
    // R11: irq gated
    irq_en = 0; wclk(1);
    chk("R11 irq disabled", {31'h0, irq}, 0);
    irq_en = 1; wclk(1);

    // R9: overrun, registers kept
    send_frame(2'b10, 0, 32'hDEAD_BEEF);
    chk("R9 overrun set", {31'h0, overrun}, 1);
    chk("R9 full held", {31'h0, full}, 1);
    check_regs("R9 regs kept");
    rx_en = 0; wclk(2);
    chk("R9 overrun cleared", {31'h0, overrun}, 0);
    rx_en = 1; wclk(1); read0();

    // R10: abort mid-frame then clean 8-bit frame
    len_sel = 2'b10; lsb_first = 0; cs_n = 0; wclk(4);
    send_byte(8'hFF, 0);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    wclk(4); cs_n = 1; wclk(8);
    chk("R10 no flag on abort", {31'h0, full}, 0);
    send_frame(2'b00, 0, 32'h3C);
    model(2'b00, 0, 32'h3C);
    chk("R10 full after clean frame", {31'h0, full}, 1);
    check_regs("R10 fresh frame");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule